// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a left/right frame clock and a serial data line) and turns it into parallel 24-bit signed samples. It supports left-aligned (MSB-justified), right-aligned (LSB-justified) and I2S framing. The right-aligned style comes in 16-, 20- and 24-bit word lengths. Each channel has its own data bus and one-cycle valid strobe. All three serial wires are oversampled by the block's own system clock through synchronizers, so the bit clock and frame clock are plain inputs and the block never drives them.

A 3-bit format code selects the framing. The block copies the code while power-down is asserted and keeps it frozen for as long as power-down stays released. Releasing power-down starts reception. The half-frame in progress at that moment is discarded, and from the first full half-frame onward every channel word is reported at the frame-clock transition that closes it.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_n` is low or `pwr_dn` is high, both valid strobes are low, both data buses read zero and all reception state is cleared.
- R2: The format code on `fmt_sel` is copied while `pwr_dn` is high. Changes to `fmt_sel` while `pwr_dn` is low have no effect on the decoded samples.
- R3: Serial data and frame clock are taken at each rising edge of `ser_bclk`, most significant bit first, in two's complement. Each bit-clock phase must last at least 2 system clocks, and data and frame clock must be stable for 3 system clocks before a rising edge.
- R4: Codes 0, 1 and 4 are right-aligned with N = 16, 20 and 24. The sample is the last N bits taken before the frame-clock transition, and earlier bits of the half-frame are ignored. It is sign-extended from bit N-1 to 24 bits.
- R5: Code 2 is left-aligned. The sample is the 24 bits taken starting at the first rising edge after the frame-clock transition, placed MSB first in bits 23..0. Later bits of the half-frame are ignored, so a shorter sender's word appears MSB-aligned.
- R6: Code 3 is I2S. The 24 bits taken starting one bit clock after the frame-clock transition form the sample, MSB-aligned. If the half-frame holds fewer than 25 bit clocks, the bit taken on the first bit clock of the next half-frame is the last bit of the word. A 16-bit word therefore reads as word followed by 8 zero bits.
- R7: In codes 0, 1, 2 and 4, frame clock high marks the left channel. In code 3, frame clock low marks the left channel.
- R8: Exactly one sample is reported per half-frame, on the channel whose half-frame just ended. The strobe is one system clock wide, and the left and right strobes are never high together.
- R9: The half-frame in progress when `pwr_dn` is released is not reported.
- R10: Codes 5, 6 and 7 produce no samples.
- R11: Frames of 32, 40, 48 and 64 bit clocks are decoded, subject to these limits: at least 32 bit clocks for code 0, at least 40 for code 1, and at least 48 for codes 2 and 4. Code 3 accepts 32 (16-bit words only), 48 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; high clears state and opens the format latch |
| fmt_sel | input | 3 | Framing code, copied while `pwr_dn` is high |
| ser_bclk | input | 1 | Serial bit clock |
| ser_frm | input | 1 | Left/right frame clock |
| ser_dat | input | 1 | Serial data |
| left_data | output | 24 | Last left-channel sample |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right-channel sample |
| right_vld | output | 1 | One-cycle strobe for a new right sample |

## Verification
The bench fills the unused slots of each half-frame with random bits. A right-aligned decoder that counts from the wrong end, or that ignores the frame size, then picks up noise instead of the word. I2S in 32-bit-clock frames moves the word's last bit into the next half-frame, and a decoder that misses this loses the LSB or shifts the word. The bench also flips `fmt_sel` while running, starts every stream mid-half-frame and uses reserved codes. A design with a transparent format latch, an unsuppressed first half-frame or a swapped channel polarity reports wrong data, an extra sample, or a sample on the wrong strobe.

// File: rtl/asr_pkg.sv
package asr_pkg;

  parameter int unsigned SMP_W = 24;
  localparam int unsigned CNT_W = $clog2(SMP_W + 1);
  localparam int unsigned LEN_SHORT = 16;
  localparam int unsigned LEN_MID = 20;

  typedef logic [SMP_W-1:0] smp_t;

  typedef enum logic [2:0] {
    FMT_LSB16 = 3'd0,
    FMT_LSB20 = 3'd1,
    FMT_MSB   = 3'd2,
    FMT_I2S   = 3'd3,
    FMT_LSB24 = 3'd4
  } fmt_e;

  function automatic logic fmt_known(logic [2:0] f);
    return f <= 3'd4;
  endfunction

  function automatic logic fmt_is_right(logic [2:0] f);
    return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
  endfunction

  // word length of a right-aligned code, 0 for anything else
  function automatic int unsigned right_len(logic [2:0] f);
    case (f)
      FMT_LSB16: return LEN_SHORT;
      FMT_LSB20: return LEN_MID;
      FMT_LSB24: return SMP_W;
      default:   return 0;
    endcase
  endfunction

  // replicate bit len-1 into all higher positions
  function automatic smp_t sext_word(smp_t raw, int unsigned len);
    smp_t r;
    if (len == 0) return raw;
    for (int i = 0; i < int'(SMP_W); i++)
      r[i] = (i < int'(len)) ? raw[i] : raw[len-1];
    return r;
  endfunction

  // place bit b at position n counted from the MSB
  function automatic smp_t put_bit(smp_t w, int unsigned n, logic b);
    smp_t r;
    r = w;
    r[SMP_W-1-n] = b;
    return r;
  endfunction

endpackage

// File: rtl/asr_edge_sync.sv
module asr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic frm_i,
  input  logic dat_i,
  output logic rise_o,
  output logic frm_o,
  output logic dat_o
);

  localparam int unsigned LANES = 3;

  logic [STAGES-1:0][LANES-1:0] pipe;
  logic                         bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '0;
      bclk_q <= 1'b0;
    end else begin
      pipe[0] <= {bclk_i, frm_i, dat_i};
      for (int i = 1; i < int'(STAGES); i++)
        pipe[i] <= pipe[i-1];
      bclk_q <= pipe[STAGES-1][2];
    end
  end

  assign rise_o = pipe[STAGES-1][2] & ~bclk_q;
  assign frm_o  = pipe[STAGES-1][1];
  assign dat_o  = pipe[STAGES-1][0];

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/asr_frame_track.sv
module asr_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rise_i,
  input  logic frm_i,
  output logic edge_o,
  output logic report_o,
  output logic prev_frm_o
);

  logic have_prev;
  logic prev_frm;
  logic armed;

  // a frame-clock transition seen at a bit-clock rise
  assign edge_o     = rise_i & have_prev & (frm_i != prev_frm);
  assign report_o   = edge_o & armed;
  assign prev_frm_o = prev_frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_frm  <= 1'b0;
      armed     <= 1'b0;
    end else if (clr) begin
      have_prev <= 1'b0;
      prev_frm  <= 1'b0;
      armed     <= 1'b0;
    end else if (rise_i) begin
      have_prev <= 1'b1;
      prev_frm  <= frm_i;
      if (edge_o) armed <= 1'b1;
    end
  end

  AST_ARM_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(edge_o)); // R9

endmodule

// File: rtl/asr_word_cap.sv
module asr_word_cap
  import asr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rise_i,
  input  logic       dat_i,
  input  logic       edge_i,
  input  logic [2:0] fmt_i,
  output smp_t       word_o
);

  smp_t             shreg;
  smp_t             cap;
  logic [CNT_W-1:0] cap_n;
  logic             lead_bit;
  logic             room;

  // left-aligned takes the bit at the transition itself, I2S starts one later
  assign lead_bit = (fmt_i == FMT_MSB);
  assign room     = (cap_n < CNT_W'(SMP_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cap   <= '0;
      cap_n <= '0;
    end else if (clr) begin
      shreg <= '0;
      cap   <= '0;
      cap_n <= '0;
    end else if (rise_i) begin
      shreg <= {shreg[SMP_W-2:0], dat_i};
      if (edge_i) begin
        cap   <= lead_bit ? put_bit('0, 0, dat_i) : '0;
        cap_n <= lead_bit ? CNT_W'(1) : '0;
      end else if (room) begin
        cap   <= put_bit(cap, int'(cap_n), dat_i);
        cap_n <= cap_n + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (fmt_is_right(fmt_i))
      word_o = sext_word(shreg, right_len(fmt_i));
    else if (fmt_i == FMT_MSB)
      word_o = cap;
    else if (fmt_i == FMT_I2S)
      word_o = room ? put_bit(cap, int'(cap_n), dat_i) : cap;
    else
      word_o = '0;
  end

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap_n <= CNT_W'(SMP_W)); // R5

  AST_LEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !clr && fmt_i == FMT_MSB) |=> (cap_n == CNT_W'(1))); // R5

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic [2:0]       fmt_sel,
  input  logic             ser_bclk,
  input  logic             ser_frm,
  input  logic             ser_dat,
  output logic [SMP_W-1:0] left_data,
  output logic             left_vld,
  output logic [SMP_W-1:0] right_data,
  output logic             right_vld
);

  localparam int unsigned NCH = 2;

  logic [2:0] fmt_q;
  logic       rise;
  logic       frm_s;
  logic       dat_s;
  logic       frm_edge;
  logic       report;
  logic       prev_frm;
  logic       ended_left;
  logic       fire;
  smp_t       word;

  // format latch: open only during power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= '0;
    else if (pwr_dn) fmt_q <= fmt_sel;
  end

  asr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk_i (ser_bclk),
    .frm_i  (ser_frm),
    .dat_i  (ser_dat),
    .rise_o (rise),
    .frm_o  (frm_s),
    .dat_o  (dat_s)
  );

  asr_frame_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pwr_dn),
    .rise_i     (rise),
    .frm_i      (frm_s),
    .edge_o     (frm_edge),
    .report_o   (report),
    .prev_frm_o (prev_frm)
  );

  asr_word_cap u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pwr_dn),
    .rise_i (rise),
    .dat_i  (dat_s),
    .edge_i (frm_edge),
    .fmt_i  (fmt_q),
    .word_o (word)
  );

  // channel that just ended: I2S inverts the frame-clock polarity
  assign ended_left = prev_frm ^ (fmt_q == FMT_I2S);
  assign fire       = report & fmt_known(fmt_q);

  for (genvar c = 0; c < int'(NCH); c++) begin : g_chan
    logic [SMP_W-1:0] data_r;
    logic             vld_r;
    logic             hit;

    assign hit = fire & (ended_left == (c == 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_r <= '0;
        vld_r  <= 1'b0;
      end else if (pwr_dn) begin
        data_r <= '0;
        vld_r  <= 1'b0;
      end else begin
        vld_r <= hit;
        if (hit) data_r <= word;
      end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_r |=> !vld_r); // R8

    if (c == 0) begin : g_left
      assign left_data = data_r;
      assign left_vld  = vld_r;
    end else begin : g_right
      assign right_data = data_r;
      assign right_vld  = vld_r;
    end
  end

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!left_vld && !right_vld && left_data == '0 && right_data == '0)); // R1

  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && $past(!pwr_dn)) |-> $stable(fmt_q)); // R2

  AST_VLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_vld, right_vld})); // R8

  AST_SEXT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (left_vld && fmt_q == FMT_LSB16) |->
      (left_data[SMP_W-1:LEN_SHORT-1] == '0 || left_data[SMP_W-1:LEN_SHORT-1] == '1)); // R4

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_known(fmt_q) |-> (!left_vld && !right_vld)); // R10

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_dn = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic        ser_bclk = 1'b0;
  logic        ser_frm = 1'b0;
  logic        ser_dat = 1'b0;
  logic [23:0] left_data, right_data;
  logic        left_vld, right_vld;

  int total = 0;
  int bad = 0;
  int vld_seen = 0;
  int cur_fmt = 0;
  logic chk_on = 1'b0;
  logic [24:0] exp_q[$];

  always #4 clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt_sel(fmt_sel),
    .ser_bclk(ser_bclk), .ser_frm(ser_frm), .ser_dat(ser_dat),
    .left_data(left_data), .left_vld(left_vld),
    .right_data(right_data), .right_vld(right_vld)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int f);
    case (f)
      0, 1, 4: return "R4";
      2:       return "R5";
      3:       return "R6";
      default: return "R10";
    endcase
  endfunction

  // right-aligned expectation computed arithmetically
  function automatic logic [23:0] exp_right(input logic [23:0] s, input int n);
    int v;
    v = int'(s) & ((1 << n) - 1);
    if (v >= (1 << (n - 1))) v = v - (1 << n);
    return v[23:0];
  endfunction

  function automatic bit frame_ok(input int f, input int bpf);
    case (f)
      0: return bpf >= 32;
      1: return bpf >= 40;
      3: return bpf == 32 || bpf >= 48;
      default: return bpf >= 48;
    endcase
  endfunction

  task automatic take(input logic is_left, input logic [23:0] d);
    logic [24:0] e;
    vld_seen++;
    if (!chk_on) return;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", "sample with none pending", {7'd0, is_left, d}, 32'd0);
      return;
    end
    e = exp_q.pop_front();
    check(is_left == e[24], "R7", "channel", {31'd0, is_left}, {31'd0, e[24]});
    check(d == e[23:0], req_of(cur_fmt), "sample (R3 bit order)", {8'd0, d}, {8'd0, e[23:0]});
  endtask

  always @(negedge clk) begin
    if (left_vld)  take(1'b1, left_data);
    if (right_vld) take(1'b0, right_data);
  end

  task automatic slot(input logic f, input logic d);
    @(negedge clk);
    ser_frm = f;
    ser_dat = d;
    repeat (4) @(negedge clk);
    ser_bclk = 1'b1;
    repeat (4) @(negedge clk);
    ser_bclk = 1'b0;
  endtask

  task automatic power_cycle(input int f);
    @(negedge clk);
    pwr_dn = 1'b1;
    fmt_sel = 3'(f);
    repeat (4) @(negedge clk);
    pwr_dn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_stream(input int f, input int bpf, input int nfr,
                            input int w, input bit flip);
    int h;
    logic lead_frm;
    logic carry;
    bit carry_v;
    logic [63:0] sl;
    logic [23:0] s, ex, w24;
    h = bpf / 2;
    carry = 1'b0;
    carry_v = 1'b0;
    cur_fmt = f;
    exp_q.delete();
    power_cycle(f);
    if (flip) fmt_sel = 3'(f) ^ 3'b101; // R2: must be ignored
    vld_seen = 0;
    chk_on = 1'b1;
    lead_frm = (f == 3) ? 1'b1 : 1'b0;
    // R9: partial lead-in half-frame, never reported
    for (int i = 0; i < 3; i++) slot(lead_frm, 1'($urandom));
    for (int fr = 0; fr < nfr; fr++) begin
      for (int hf = 0; hf < 2; hf++) begin
        s = 24'($urandom);
        for (int i = 0; i < 64; i++) sl[i] = 1'($urandom);
        ex = 24'd0;
        if (f == 0 || f == 1 || f == 4) begin
          int n;
          n = (f == 0) ? 16 : (f == 1) ? 20 : 24;
          for (int k = 0; k < n; k++) sl[h - n + k] = s[n - 1 - k];
          ex = exp_right(s, n);
        end else if (f == 2) begin
          for (int k = 0; k < 24; k++) sl[k] = s[23 - k];
          ex = s;
        end else if (f == 3) begin
          w24 = s & ~((24'd1 << (24 - w)) - 24'd1);
          if (carry_v) sl[0] = carry;
          carry_v = 1'b0;
          for (int p = 1; p <= 24; p++) begin
            if (p < h) sl[p] = w24[24 - p];
            else if (p == h) begin carry = w24[24 - p]; carry_v = 1'b1; end
          end
          ex = w24;
        end
        if (f <= 4) exp_q.push_back({(hf == 0), ex});
        for (int i = 0; i < h; i++) slot((hf == 0) ? ~lead_frm : lead_frm, sl[i]);
      end
    end
    // tail: transition that closes the last half-frame
    slot(~lead_frm, carry_v ? carry : 1'($urandom));
    slot(~lead_frm, 1'($urandom));
    repeat (40) @(negedge clk);
    if (f <= 4)
      check(exp_q.size() == 0, "R8 R11", "samples still pending", 32'(exp_q.size()), 32'd0);
    else
      check(vld_seen == 0, "R10", "strobes on reserved code", 32'(vld_seen), 32'd0);
    chk_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(left_vld == 1'b0 && right_vld == 1'b0, "R1", "strobes in reset",
          {30'd0, left_vld, right_vld}, 32'd0);
    check(left_data == 24'd0 && right_data == 24'd0, "R1", "data in reset",
          {8'd0, left_data | right_data}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(left_vld == 1'b0 && left_data == 24'd0, "R1", "after reset",
          {7'd0, left_vld, left_data}, 32'd0);

    // R11: directed frame sizes per code
    run_stream(0, 32, 3, 16, 1'b0);
    run_stream(0, 40, 2, 16, 1'b0);
    run_stream(0, 48, 2, 16, 1'b0);
    run_stream(0, 64, 2, 16, 1'b0);
    run_stream(1, 40, 2, 20, 1'b0);
    run_stream(1, 48, 2, 20, 1'b0);
    run_stream(1, 64, 2, 20, 1'b0);
    run_stream(2, 48, 2, 24, 1'b0);
    run_stream(2, 64, 2, 24, 1'b0);
    run_stream(3, 32, 3, 16, 1'b0);
    run_stream(3, 48, 2, 24, 1'b0);
    run_stream(3, 48, 2, 16, 1'b0);
    run_stream(3, 64, 2, 24, 1'b0);
    run_stream(3, 64, 2, 16, 1'b0);
    run_stream(4, 48, 2, 24, 1'b0);
    run_stream(4, 64, 2, 24, 1'b0);

    // R2: selector moves while running
    run_stream(0, 32, 2, 16, 1'b1);
    run_stream(3, 48, 2, 24, 1'b1);

    // R1: power-down mid-operation clears outputs
    @(negedge clk);
    pwr_dn = 1'b1;
    repeat (3) @(negedge clk);
    check(left_data == 24'd0 && right_data == 24'd0 && !left_vld && !right_vld,
          "R1", "outputs under power-down", {8'd0, left_data | right_data}, 32'd0);

    // R10: reserved codes
    run_stream(5, 48, 2, 24, 1'b0);
    run_stream(7, 64, 2, 24, 1'b0);

    // random mix
    for (int r = 0; r < 14; r++) begin
      int f, bpf, w;
      f = int'($urandom % 5);
      do begin
        case ($urandom % 4)
          0: bpf = 32;
          1: bpf = 40;
          2: bpf = 48;
          default: bpf = 64;
        endcase
      end while (!frame_ok(f, bpf));
      w = (bpf == 32) ? 16 : (($urandom % 2) != 0 ? 24 : 16);
      run_stream(f, bpf, 2, w, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule